// File: doc/BRIEF.md
# Bitstream Bit-Field Reader

This block turns a stream of 32-bit words into variable-length bit fields, most significant bit first, as a compressed-audio header or side-information parser consumes them. Words arrive on a valid/ready input and are queued in a 64-word FIFO. A partly used word is held in a pop register. The caller writes a field width N. The block then shows the next N bits of the stream, right-aligned, on `pop_data`, and a pop strobe consumes them. A field that needs more bits than remain in the pop register continues into the head word of the FIFO.

A second read output gives the number of zero bits before the first one bit at the current stream position. It consumes nothing, so a parser can size an exponential-Golomb or unary code before it pops. A status word reports three things: the bits left in the pop register, the FIFO word count, and whether the block wants more data from upstream. A control write stores an input enable and can fire a one-shot flush.

Top module: `bitfield_reader`

## Requirements
- R1: After reset the input enable is clear, the width N is 32, `in_ready` and `pop_ready` are 0 and `status` is all zero.
- R2: `pop_data` holds the next N unconsumed stream bits, the first of them at bit N-1 and the bits above N-1 zero. Each word contributes its bit 31 first. A pop strobe accepted while `pop_ready` is high removes exactly those N bits. A field may span the pop register and the next FIFO word.
- R3: A write on `cnt_we` sets N to `cnt_wdata` for values 1 to 32. A value of 0, or any value above 32, sets N to 32. The new N applies from the next cycle.
- R4: `pop_ready` is high exactly when at least N bits are buffered across the pop register and the FIFO. A pop strobe while it is low changes no state.
- R5: `lzc` gives the number of zero bits from the current position up to the first one bit, looking at no more than 32 buffered bits. It stops at the end of the buffered data and reads 32 when the next 32 bits are all zero. It never consumes bits.
- R6: `status[4:0]` is the number of unconsumed bits in the pop register, from 0 to 31. `status[11:5]` is the FIFO word count. `status[12]` is 0.
- R7: A control write with `cfg_wdata[0]`=1 empties the FIFO and the pop register by the next cycle. In that cycle no word is accepted and no pop takes effect. Every control write stores `cfg_wdata[1]` as the input enable.
- R8: `in_ready` is high only while the input enable is set, the FIFO holds fewer than 64 words and no flush write is present. A word is queued only on `in_valid` and `in_ready` together.
- R9: `status[13]` is high exactly when the input enable is set and the FIFO holds fewer than 48 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 2 | Bit 1 input enable, bit 0 flush trigger |
| cnt_we | input | 1 | Field-width write strobe |
| cnt_wdata | input | 6 | Field width N |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word, bit 31 first in the stream |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| pop_req | input | 1 | Consume the field shown on pop_data |
| pop_ready | output | 1 | At least N bits are buffered |
| pop_data | output | 32 | Next N bits, right-aligned |
| lzc | output | 6 | Leading-zero count at the current position |
| status | output | 14 | Request, reserved, word count, bits left |

## Verification
Fields are drawn with random widths over random words. This exposes errors in MSB-first order, in right alignment and in the span across word boundaries. Zero-heavy words, single set bits and all-zero words exercise the leading-zero count at every offset, its saturation at 32 and its stop at the end of buffered data. A long push-only run fills the FIFO and separates the 48-word request threshold from the 64-word full stop. A pop-only run drains it and shows where `pop_ready` falls for each N. Disabled-input and flush phases, with pushes and pops offered in the same cycle, show that the enable and the flush win over the handshake.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int WORD_W  = 32;
  localparam int NSEL_W  = 6;   // field width 1..32
  localparam int LEFT_W  = 5;   // bits left in pop register 0..31
  localparam int CAT_W   = 2 * WORD_W;
  localparam int STAT_W  = 14;
  localparam int STAT_CNT_W = 7;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NSEL_W-1:0] nsel_t;
  typedef logic [LEFT_W-1:0] left_t;
endpackage

// File: rtl/bsr_word_fifo.sv
module bsr_word_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = ptr_inc(wr_q);
      if (pop)  rd_d = ptr_inc(rd_q);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/bsr_lzc.sv
module bsr_lzc
  import bsr_pkg::*;
(
  input  word_t win,
  output nsel_t zeros
);
  always_comb begin
    zeros = NSEL_W'(WORD_W);
    for (int i = 0; i < WORD_W; i++) begin
      if (win[i]) zeros = NSEL_W'(WORD_W - 1 - i);
    end
  end
endmodule

// File: rtl/bsr_bit_window.sv
module bsr_bit_window
  import bsr_pkg::*;
(
  input  word_t popreg,
  input  word_t head,
  input  logic  head_valid,
  input  left_t bits_left,
  input  nsel_t nsel,
  output word_t field,
  output word_t lz_win
);
  logic [CAT_W-1:0] cat, fshift, lshift, fmask, fill;
  logic [NSEL_W:0]  sh;

  assign cat = {popreg, head};
  // Next stream bit sits at WORD_W + bits_left - 1 of the concatenation.
  assign sh     = (NSEL_W+1)'(WORD_W) + (NSEL_W+1)'(bits_left) - (NSEL_W+1)'(nsel);
  assign fshift = cat >> sh;
  assign fmask  = (CAT_W'(1) << nsel) - CAT_W'(1);
  assign field  = fshift[WORD_W-1:0] & fmask[WORD_W-1:0];

  // Positions past the end of buffered data read as ones so the count stops there.
  assign lshift = cat >> bits_left;
  assign fill   = (CAT_W'(1) << (NSEL_W'(WORD_W) - NSEL_W'(bits_left))) - CAT_W'(1);
  assign lz_win = head_valid ? lshift[WORD_W-1:0]
                             : (lshift[WORD_W-1:0] | fill[WORD_W-1:0]);
endmodule

// File: rtl/bitfield_reader.sv
module bitfield_reader
  import bsr_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int REQ_NUM   = 3,
  parameter int REQ_DEN   = 4,
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int REQ_LEVEL = (DEPTH * REQ_NUM) / REQ_DEN
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_wdata,
  input  logic        cnt_we,
  input  logic [5:0]  cnt_wdata,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  input  logic        pop_req,
  output logic        pop_ready,
  output logic [31:0] pop_data,
  output logic [5:0]  lzc,
  output logic [13:0] status
);
  logic    enable_q, enable_d;
  nsel_t   n_q, n_d;
  left_t   bits_q, bits_d;
  word_t   popreg_q, popreg_d;
  word_t   head, lz_win;
  logic [CW-1:0] fifo_count;
  logic    cfg_flush, need_head, head_valid, pop_fire, fifo_pop, push_fire, fifo_full;

  assign cfg_flush  = cfg_we && cfg_wdata[0];
  assign head_valid = (fifo_count != '0);
  assign fifo_full  = (fifo_count == CW'(DEPTH));
  assign need_head  = (n_q > {1'b0, bits_q});
  assign pop_ready  = !need_head || head_valid;
  assign pop_fire   = pop_req && pop_ready && !cfg_flush;
  assign fifo_pop   = pop_fire && need_head;
  assign in_ready   = enable_q && !fifo_full && !cfg_flush;
  assign push_fire  = in_valid && in_ready;

  bsr_word_fifo #(.DEPTH(DEPTH), .W(WORD_W)) i_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (cfg_flush),
    .push     (push_fire),
    .push_data(in_data),
    .pop      (fifo_pop),
    .head     (head),
    .count    (fifo_count)
  );

  bsr_bit_window i_window (
    .popreg    (popreg_q),
    .head      (head),
    .head_valid(head_valid),
    .bits_left (bits_q),
    .nsel      (n_q),
    .field     (pop_data),
    .lz_win    (lz_win)
  );

  bsr_lzc i_lzc (
    .win  (lz_win),
    .zeros(lzc)
  );

  always_comb begin
    enable_d = enable_q;
    n_d      = n_q;
    bits_d   = bits_q;
    popreg_d = popreg_q;
    if (cfg_we) enable_d = cfg_wdata[1];
    if (cnt_we) begin
      if (cnt_wdata == '0 || cnt_wdata > NSEL_W'(WORD_W)) n_d = NSEL_W'(WORD_W);
      else                                               n_d = cnt_wdata;
    end
    if (cfg_flush) begin
      bits_d = '0;
    end else if (pop_fire) begin
      if (need_head) begin
        bits_d   = LEFT_W'(NSEL_W'(WORD_W) + NSEL_W'(bits_q) - n_q);
        popreg_d = head;
      end else begin
        bits_d   = bits_q - LEFT_W'(n_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      n_q      <= NSEL_W'(WORD_W);
      bits_q   <= '0;
      popreg_q <= '0;
    end else begin
      enable_q <= enable_d;
      n_q      <= n_d;
      bits_q   <= bits_d;
      popreg_q <= popreg_d;
    end
  end

  assign status = {enable_q && (fifo_count < CW'(REQ_LEVEL)),
                   1'b0,
                   STAT_CNT_W'(fifo_count),
                   bits_q};

  assert_pop_in_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && pop_ready && !cfg_flush && !need_head)
      |=> (bits_q == $past(bits_q) - $past(n_q[LEFT_W-1:0])));
  assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_ready && !cfg_we) |=> $stable(bits_q));
  assert_lzc_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lzc <= NSEL_W'(WORD_W));
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_flush |=> (fifo_count == '0 && bits_q == '0));
  assert_disabled_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_q |-> !in_ready);
  assert_req_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status[13] |-> (enable_q && status[11:5] < STAT_CNT_W'(REQ_LEVEL)));
endmodule

// File: tb/test_bitfield_reader.sv
module test_bitfield_reader;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_wdata = '0;
  logic        cnt_we = 1'b0;
  logic [5:0]  cnt_wdata = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        pop_req = 1'b0;
  logic        pop_ready;
  logic [31:0] pop_data;
  logic [5:0]  lzc;
  logic [13:0] status;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit          en_m = 1'b0;
  int          n_m = 32;
  bit          part[$];
  logic [31:0] wq[$];

  // stimulus knobs (percentages)
  int p_push = 0, p_pop = 0, p_cnt = 0, p_cfg = 0, p_flush = 0, dmode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitfield_reader i_bitfield_reader (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pop_req(pop_req), .pop_ready(pop_ready),
    .pop_data(pop_data), .lzc(lzc), .status(status)
  );

  function automatic bit sbit(int i);
    int k;
    if (i < part.size()) return part[i];
    k = i - part.size();
    return wq[k/32][31 - (k%32)];
  endfunction

  function automatic int avail();
    return part.size() + 32 * wq.size();
  endfunction

  function automatic bit exp_pop_ready();
    return avail() >= n_m;
  endfunction

  function automatic bit exp_in_ready();
    return en_m && (wq.size() < 64) && !(cfg_we && cfg_wdata[0]);
  endfunction

  function automatic logic [31:0] exp_field();
    logic [31:0] d = '0;
    for (int i = 0; i < n_m; i++) d = {d[30:0], sbit(i)};
    return d;
  endfunction

  function automatic int exp_lzc();
    int z = 0;
    while (z < 32 && z < avail() && sbit(z) == 1'b0) z++;
    return z;
  endfunction

  function automatic logic [13:0] exp_status();
    return {en_m && (wq.size() < 48), 1'b0, 7'(wq.size()), 5'(part.size())};
  endfunction

  // model update on the same edge the design registers
  always @(posedge clk) begin
    if (!rst_n) begin
      en_m = 1'b0; n_m = 32; part.delete(); wq.delete();
    end else begin
      bit fl, pr, ir;
      fl = cfg_we && cfg_wdata[0];
      pr = exp_pop_ready();
      ir = exp_in_ready();
      if (fl) begin
        part.delete(); wq.delete();
      end else begin
        if (pop_req && pr) begin
          if (n_m > part.size()) begin
            logic [31:0] w;
            w = wq.pop_front();
            for (int b = 31; b >= 0; b--) part.push_back(w[b]);
          end
          for (int i = 0; i < n_m; i++) void'(part.pop_front());
        end
        if (in_valid && ir) wq.push_back(in_data);
      end
      if (cfg_we) en_m = cfg_wdata[1];
      if (cnt_we) n_m = (cnt_wdata == 0 || cnt_wdata > 32) ? 32 : int'(cnt_wdata);
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R8", "in_ready", in_ready, exp_in_ready());
    chk("R4", "pop_ready", pop_ready, exp_pop_ready());
    if (exp_pop_ready()) chk("R2 R3", "pop_data", pop_data, exp_field());
    chk("R5", "lzc", lzc, exp_lzc());
    chk("R6 R7", "status", status[12:0], exp_status() & 14'h1FFF);
    chk("R9", "request", status[13], exp_status() >> 13);
  endtask

  function automatic logic [31:0] gen_word();
    int r = $urandom % 6;
    if (dmode == 0) return $urandom;
    case (r)
      0, 1:    return 32'h0;
      2:       return 32'h1 << ($urandom % 32);
      3:       return $urandom >> ($urandom % 32);
      default: return $urandom & $urandom & $urandom;
    endcase
  endfunction

  task automatic drive();
    in_valid = ($urandom % 100) < p_push;
    in_data  = gen_word();
    pop_req  = ($urandom % 100) < p_pop;
    cnt_we   = ($urandom % 100) < p_cnt;
    cnt_wdata = (($urandom % 8) == 0) ? 6'(($urandom % 2) ? 0 : 33 + $urandom % 31)
                                      : 6'(1 + $urandom % 32);
    cfg_we   = ($urandom % 100) < p_cfg;
    cfg_wdata = {(($urandom % 8) != 0), (($urandom % 100) < p_flush)};
  endtask

  task automatic run(int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare();
      drive();
    end
  endtask

  task automatic set_knobs(int pu, int po, int cn, int cf, int fl, int dm);
    p_push = pu; p_pop = po; p_cnt = cn; p_cfg = cf; p_flush = fl; dmode = dm;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "in_ready at reset", in_ready, 0);
    chk("R1", "pop_ready at reset", pop_ready, 0);
    chk("R1", "status at reset", status, 0);
    rst_n = 1'b1;
    run(3);
    // enable input through control write (R7 enable bit)
    @(negedge clk); compare();
    cfg_we = 1'b1; cfg_wdata = 2'b10;
    @(negedge clk); compare();
    cfg_we = 1'b0;
    // R1: default width 32 pops one whole word
    in_valid = 1'b1; in_data = 32'hA5C3_0F81;
    @(negedge clk); compare();
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1", "default width field", pop_data, 32'hA5C3_0F81);
    compare();
    // fill past full (R8, R9)
    set_knobs(100, 0, 0, 0, 0, 0); run(80);
    // drain with varied widths (R2, R3, R4)
    set_knobs(0, 70, 30, 0, 0, 0); run(500);
    // zero-heavy mixed traffic (R5)
    set_knobs(40, 50, 20, 0, 0, 1); run(3000);
    // input disabled (R8)
    @(negedge clk); compare();
    cfg_we = 1'b1; cfg_wdata = 2'b00;
    @(negedge clk); compare();
    cfg_we = 1'b0;
    set_knobs(100, 0, 0, 0, 0, 0); p_cfg = 0; run(1);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk); compare();
      in_valid = 1'b1; in_data = $urandom; cfg_we = 1'b0; pop_req = 1'b1;
    end
    // re-enable, then flush during traffic (R7)
    @(negedge clk); compare();
    cfg_we = 1'b1; cfg_wdata = 2'b10;
    set_knobs(80, 30, 10, 0, 0, 1);
    run(40);
    @(negedge clk); compare();
    cfg_we = 1'b1; cfg_wdata = 2'b11; in_valid = 1'b1; pop_req = 1'b1;
    @(negedge clk); compare();
    cfg_we = 1'b0;
    // random mix with occasional flush and enable toggling
    set_knobs(50, 50, 15, 3, 20, 1); run(3000);
    set_knobs(60, 40, 15, 2, 10, 0); run(2000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule